// File: doc/BRIEF.md
# PRG/CHR Bank Translator

This block is the address-translation core of a cartridge controller. Program-side CPU addresses from 0x6000 to 0xFFFF and video pattern addresses from 0x0000 to 0x1FFF are mapped onto physical ROM offsets. The mapping comes from a set of byte-wide registers loaded by CPU bus writes. There are four program bank registers, eight low bytes and eight high bytes for the pattern banks, and four configuration registers.

Configuration register 0 holds the layout settings. Its bits [1:0] pick the program layout. The choices are two 16 KB windows, four 8 KB windows, or three 8 KB windows with a fixed final bank. That last layout can also place an extra 8 KB window at 0x6000. Its bits [4:3] set the pattern bank size to 8, 4, 2 or 1 KB. Bank numbers are trimmed to the ROM sizes given by parameters. The whole configuration set is also exposed so that neighbouring logic, such as nametable control, can decode its own fields.

Translation is purely combinational from the address inputs. Register loads take effect one clock after the write cycle.

Top module: `prg_chr_bank_map`

## Requirements
- R1: After reset every program, pattern-low, pattern-high and configuration register reads as 0xFF. The block therefore starts in program layout 3 and pattern size 1 KB.
- R2: Writes decode `cpu_addr & 0xF007`. The value 0x8000+n (n=0..3) loads program register n, 0x9000+n (n=0..7) loads pattern-low n, and 0xA000+n loads pattern-high n. A masked value of 0x8004 to 0x8007 loads nothing.
- R3: Any write with `cpu_addr[15:12]`=0xD loads configuration register `cpu_addr[1:0]`. `cfg_q[8k+7:8k]` is register k.
- R4: In program layout 1, 0x8000–0xBFFF maps 16 KB bank program[0] and 0xC000–0xFFFF maps 16 KB bank program[2].
- R5: In layout 2 with config0 bit 2 set, 8 KB window w (w = `cpu_addr[14:13]`) maps bank program[w].
- R6: In layout 2 with config0 bit 2 clear, windows 0 to 2 map program[0..2] and window 3 (0xE000) maps the last 8 KB bank of the ROM.
- R7: In layout 2 with bit 2 clear and config0 bit 7 set, 0x6000–0x7FFF is valid and maps 8 KB bank program[3].
- R8: `prg_valid` is 0 below 0x6000 and 0 for 0x6000–0x7FFF unless R7 applies. It is 1 for all of 0x8000–0xFFFF.
- R9: In layouts 0 and 3, window w maps 8 KB bank program[w].
- R10: Pattern size code s = config0[4:3] gives banks of 8192>>s bytes. The bank covering `vid_addr` uses register index (vid_addr / size) × (8 >> s).
- R11: The pattern bank number is low[i] | (high[i] << 8). The physical address is bank × size + (vid_addr mod size).
- R12: Physical addresses are reduced modulo the ROM sizes, 2^(13+PRG_BANK_W) and 2^(10+CHR_BANK_W) bytes.
- R13: Nothing is loaded while `cpu_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads 0xFF into all registers |
| cpu_wr | input | 1 | Write strobe, one load per high cycle |
| cpu_addr | input | 16 | CPU address, used for write decode and program translation |
| cpu_wdata | input | 8 | Write data |
| vid_addr | input | 13 | Video pattern address |
| prg_valid | output | 1 | Program ROM responds to `cpu_addr` |
| prg_addr | output | 13+PRG_BANK_W | Physical program ROM address |
| chr_addr | output | 10+CHR_BANK_W | Physical pattern ROM address |
| cfg_q | output | 32 | The four configuration registers, packed |

## Verification
The hardest state to reach from the ports is the 0x6000 window. It needs layout 2, bit 2 clear and bit 7 set all at once in config0. With random configuration bytes that happens in about one write in sixteen. The window also has to be probed in the same stretch of cycles. The stimulus therefore biases config0 writes towards layout 2 and mixes in directed loads that enable and disable the window. Aliased write addresses with junk in bits 11:3 are also driven, to show that the 0xF007 decode ignores those bits.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  typedef logic [3:0][7:0]  prg_regs_t;
  typedef logic [7:0][15:0] chr_nums_t;
  typedef logic [3:0][7:0]  cfg_regs_t;

  typedef struct packed {
    logic       hit;
    logic [8:0] bank8k;
  } prg_sel_t;

  // Program 8 KB bank selection for CPU window win = addr[15:13].
  function automatic prg_sel_t prg_select(input logic [7:0] cfg0,
                                          input prg_regs_t regs,
                                          input logic [2:0] win);
    prg_sel_t   r;
    logic [1:0] slot;
    slot     = win[1:0];
    r.hit    = 1'b0;
    r.bank8k = '0;
    if (!win[2]) begin
      if (win == 3'b011 && cfg0[1:0] == 2'd2 && !cfg0[2] && cfg0[7]) begin
        r.hit    = 1'b1;
        r.bank8k = {1'b0, regs[3]};
      end
    end else begin
      r.hit = 1'b1;
      unique case (cfg0[1:0])
        2'd1: r.bank8k = slot[1] ? {regs[2], slot[0]} : {regs[0], slot[0]};
        2'd2: begin
          if (!cfg0[2] && slot == 2'd3) r.bank8k = '1;
          else                          r.bank8k = {1'b0, regs[slot]};
        end
        default: r.bank8k = {1'b0, regs[slot]};
      endcase
    end
    return r;
  endfunction

  // Pattern bank number in 1 KB units for segment seg = vid[12:10].
  function automatic logic [18:0] chr_select(input logic [1:0] size_code,
                                             input chr_nums_t nums,
                                             input logic [2:0] seg);
    logic [18:0] b;
    unique case (size_code)
      2'd0: b = {nums[0], seg};
      2'd1: b = {1'b0, nums[{seg[2], 2'b00}], seg[1:0]};
      2'd2: b = {2'b0, nums[{seg[2:1], 1'b0}], seg[0]};
      default: b = {3'b0, nums[seg]};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bank_map_regs.sv
module bank_map_regs
  import bank_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output prg_regs_t   prg_q,
  output chr_nums_t   chr_q,
  output cfg_regs_t   cfg_q
);
  localparam int NPRG = 4;
  localparam int NCHR = 8;
  localparam int NCFG = 4;
  localparam logic [7:0] RST_VAL = 8'hFF;

  logic [15:0] dec_addr;
  logic        prg_grp, lo_grp, hi_grp, cfg_grp;
  logic [7:0]  lo_q [NCHR];
  logic [7:0]  hi_q [NCHR];

  assign dec_addr = cpu_addr & 16'hF007;
  assign prg_grp  = cpu_wr && dec_addr[15:12] == 4'h8 && !dec_addr[2];
  assign lo_grp   = cpu_wr && dec_addr[15:12] == 4'h9;
  assign hi_grp   = cpu_wr && dec_addr[15:12] == 4'hA;
  assign cfg_grp  = cpu_wr && cpu_addr[15:12] == 4'hD;

  for (genvar i = 0; i < NPRG; i++) begin : g_prg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   prg_q[i] <= RST_VAL;
      else if (prg_grp && dec_addr[1:0] == 2'(i))   prg_q[i] <= cpu_wdata;
    end
  end

  for (genvar i = 0; i < NCHR; i++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= RST_VAL;
        hi_q[i] <= RST_VAL;
      end else begin
        if (lo_grp && dec_addr[2:0] == 3'(i)) lo_q[i] <= cpu_wdata;
        if (hi_grp && dec_addr[2:0] == 3'(i)) hi_q[i] <= cpu_wdata;
      end
    end
    assign chr_q[i] = {hi_q[i], lo_q[i]};
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cfg_q[i] <= RST_VAL;
      else if (cfg_grp && cpu_addr[1:0] == 2'(i))   cfg_q[i] <= cpu_wdata;
    end
  end

endmodule

// File: rtl/bank_map_prg.sv
module bank_map_prg
  import bank_map_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  localparam int PRG_AW    = 13 + PRG_BANK_W
) (
  input  logic [7:0]        cfg0,
  input  prg_regs_t         regs,
  input  logic [15:0]       cpu_addr,
  output logic              prg_valid,
  output logic [PRG_AW-1:0] prg_addr
);
  prg_sel_t sel;

  assign sel       = prg_select(cfg0, regs, cpu_addr[15:13]);
  assign prg_valid = sel.hit;
  assign prg_addr  = PRG_AW'({sel.bank8k, cpu_addr[12:0]});

endmodule

// File: rtl/bank_map_chr.sv
module bank_map_chr
  import bank_map_pkg::*;
#(
  parameter int CHR_BANK_W = 10,
  localparam int CHR_AW    = 10 + CHR_BANK_W
) (
  input  logic [1:0]        size_code,
  input  chr_nums_t         nums,
  input  logic [12:0]       vid_addr,
  output logic [CHR_AW-1:0] chr_addr
);
  logic [18:0] bank1k;

  assign bank1k   = chr_select(size_code, nums, vid_addr[12:10]);
  assign chr_addr = CHR_AW'({bank1k, vid_addr[9:0]});

endmodule

// File: rtl/prg_chr_bank_map.sv
module prg_chr_bank_map
  import bank_map_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 10,
  localparam int PRG_AW    = 13 + PRG_BANK_W,
  localparam int CHR_AW    = 10 + CHR_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [12:0]       vid_addr,
  output logic              prg_valid,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [31:0]       cfg_q
);
  prg_regs_t prg_q;
  chr_nums_t chr_q;
  cfg_regs_t cfg_r;
  logic [7:0] cfg0;

  bank_map_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .prg_q    (prg_q),
    .chr_q    (chr_q),
    .cfg_q    (cfg_r)
  );

  assign cfg0  = cfg_r[0];
  assign cfg_q = cfg_r;

  bank_map_prg #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .cfg0     (cfg0),
    .regs     (prg_q),
    .cpu_addr (cpu_addr),
    .prg_valid(prg_valid),
    .prg_addr (prg_addr)
  );

  bank_map_chr #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .size_code(cfg0[4:3]),
    .nums     (chr_q),
    .vid_addr (vid_addr),
    .chr_addr (chr_addr)
  );

endmodule

// File: rtl/bank_map_checker.sv
module bank_map_checker #(
  parameter int PRG_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              prg_valid,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [31:0]       cfg_q
);
  logic win_on;
  assign win_on = cfg_q[1:0] == 2'd2 && !cfg_q[2] && cfg_q[7];

  a_r8_below_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> !prg_valid);

  a_r8_rom_space_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> prg_valid);

  a_r7_window_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011 && prg_valid) |-> win_on);

  a_r6_fixed_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd2 && !cfg_q[2] && cpu_addr[15:13] == 3'b111)
      |-> (&prg_addr[PRG_AW-1:13]));

  a_r3_cfg0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'hD && cpu_addr[1:0] == 2'd0)
      |=> cfg_q[7:0] == $past(cpu_wdata));

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(cfg_q));

endmodule

bind prg_chr_bank_map bank_map_checker #(.PRG_AW(PRG_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .prg_valid(prg_valid),
  .prg_addr (prg_addr),
  .cfg_q    (cfg_q)
);

// File: tb/tb_prg_chr_bank_map.sv
module tb_prg_chr_bank_map;
  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANK_W = 8;
  localparam int CHR_BANK_W = 10;
  localparam int PRG_AW = 13 + PRG_BANK_W;
  localparam int CHR_AW = 10 + CHR_BANK_W;
  localparam int PRG_BYTES = 1 << PRG_AW;
  localparam int CHR_BYTES = 1 << CHR_AW;

  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [12:0] vid_addr = '0;
  logic prg_valid;
  logic [PRG_AW-1:0] prg_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [31:0] cfg_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_prg [4];
  int m_lo [8];
  int m_hi [8];
  int m_cfg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_chr_bank_map #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .vid_addr(vid_addr), .prg_valid(prg_valid),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .cfg_q(cfg_q));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench view of the write decode
  task automatic model_write(input int a, input int d);
    int m;
    m = a & 'hF007;
    if (m >= 'h8000 && m <= 'h8003) m_prg[m & 3] = d;
    else if (m >= 'h9000 && m <= 'h9007) m_lo[m & 7] = d;
    else if (m >= 'hA000 && m <= 'hA007) m_hi[m & 7] = d;
    else if (a >= 'hD000 && a <= 'hDFFF) m_cfg[a & 3] = d;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
    model_write(int'(a), int'(d));
  endtask

  function automatic string prg_req(input int a);
    int md = m_cfg[0] & 3;
    if (a < 'h8000) return (a >= 'h6000 && md == 2 && !m_cfg[0][2] && m_cfg[0][7]) ? "R7" : "R8";
    if (md == 1) return "R4";
    if (md == 2) return m_cfg[0][2] ? "R5" : "R6";
    return "R9";
  endfunction

  // Returns -1 for invalid, else the physical byte offset
  function automatic int exp_prg(input int a);
    int md = m_cfg[0] & 3;
    bit b2 = m_cfg[0][2];
    bit b7 = m_cfg[0][7];
    int phys, w;
    if (a < 'h6000) return -1;
    if (a < 'h8000) begin
      if (md == 2 && !b2 && b7) phys = m_prg[3] * 8192 + (a - 'h6000);
      else return -1;
    end else if (md == 1) begin
      phys = ((a >= 'hC000) ? m_prg[2] : m_prg[0]) * 16384 + (a % 16384);
    end else begin
      w = (a - 'h8000) / 8192;
      if (md == 2 && !b2 && w == 3) phys = (PRG_BYTES - 8192) + (a % 8192);
      else phys = m_prg[w] * 8192 + (a % 8192);
    end
    return phys % PRG_BYTES;
  endfunction

  function automatic int exp_chr(input int v);
    int s = (m_cfg[0] >> 3) & 3;
    int unit = 8192 >> s;
    int idx = (v / unit) * (8 >> s);
    int num = m_lo[idx] | (m_hi[idx] << 8);
    return (num * unit + v % unit) % CHR_BYTES;
  endfunction

  task automatic probe_cpu(input int a);
    int e;
    @(negedge clk);
    cpu_addr = 16'(a);
    #1;
    e = exp_prg(a);
    if (e < 0) chk({prg_req(a), " valid"}, prg_valid, 0);
    else begin
      chk({prg_req(a), " valid"}, prg_valid, 1);
      chk({prg_req(a), " addr"}, prg_addr, e);
    end
  endtask

  task automatic probe_vid(input int v, input string req);
    @(negedge clk);
    vid_addr = 13'(v);
    #1;
    chk(req, chr_addr, exp_chr(v));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin m_prg[i] = 'hFF; m_cfg[i] = 'hFF; end
    for (int i = 0; i < 8; i++) begin m_lo[i] = 'hFF; m_hi[i] = 'hFF; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset values seen at the ports
    #1;
    chk("R1 cfg", cfg_q, 32'hFFFF_FFFF);
    probe_cpu('h8000);
    probe_cpu('h6000);
    probe_vid('h0000, "R1 chr");
    probe_cpu('h0000);

    // R2: aliased and ignored program writes
    bus_write(16'h8FF1, 8'h23);          // aliases index 1
    probe_cpu('hA010);
    bus_write(16'h8004, 8'h77);          // must load nothing
    probe_cpu('h8000);
    chk("R2 ignored 8004", prg_addr, 32'hFF * 8192);

    // R3: config write at an aliased address, layout 2 with window
    bus_write(16'hD7F0, 8'h82);
    @(negedge clk); #1;
    chk("R3 cfg0", cfg_q[7:0], 8'h82);
    bus_write(16'hDAB3, 8'h5A);
    @(negedge clk); #1;
    chk("R3 cfg3", cfg_q[31:24], 8'h5A);
    bus_write(16'h8003, 8'h41);
    probe_cpu('h6123);                   // R7
    probe_cpu('hE456);                   // R6
    probe_cpu('hC000);

    // R13: strobe low, data on bus
    @(negedge clk);
    cpu_wr = 0; cpu_addr = 16'hD000; cpu_wdata = 8'h00;
    @(negedge clk); #1;
    chk("R13 no load", cfg_q[7:0], 8'h82);

    // R4 and R12: 16 KB layout, bank number past ROM size
    bus_write(16'hD000, 8'h01);
    bus_write(16'h8000, 8'hC0);
    probe_cpu('h8000);
    chk("R12 prg wrap", prg_addr, (32'h180 % 256) * 8192);
    probe_cpu('hC7FF);
    probe_cpu('h7000);

    // R11 and R12: 16-bit pattern bank number
    bus_write(16'hD000, 8'h18);
    bus_write(16'h9005, 8'h34);
    bus_write(16'hA005, 8'h12);
    probe_vid('h1400, "R11 chr 1k");
    chk("R12 chr wrap", chr_addr, (32'h1234 * 1024) % CHR_BYTES);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int r, a, d;
      r = int'($urandom_range(0, 9));
      d = int'($urandom_range(0, 255));
      case (r)
        0: a = 'h8000 | int'($urandom_range(0, 'hFFF));
        1: a = 'h9000 | int'($urandom_range(0, 'hFFF));
        2: a = 'hA000 | int'($urandom_range(0, 'hFFF));
        3: a = 'hB000 | int'($urandom_range(0, 'hFFF));
        4: a = 'hC000 | int'($urandom_range(0, 'hFFF));
        5: begin a = 'hD000 | int'($urandom_range(0, 'hFFF)) & 'hFFFC;
                 d = (d & 'h78) | 'h82; end     // layout 2 biased
        6: a = 'hD000 | int'($urandom_range(0, 'hFFF));
        7: a = 'h5000 | int'($urandom_range(0, 'hFFF));
        default: a = 'h8000 | int'($urandom_range(0, 7));
      endcase
      bus_write(16'(a), 8'(d));
      probe_cpu(int'($urandom_range('h5000, 'hFFFF)));
      probe_cpu('h6000 | int'($urandom_range(0, 'h1FFF)));
      probe_vid(int'($urandom_range(0, 'h1FFF)), "R10 chr");
    end

    // R5 and R9 directed, R10 all sizes
    bus_write(16'hD000, 8'h06);
    for (int w = 0; w < 4; w++) probe_cpu('h8000 + w * 'h2000 + 5);
    probe_cpu('h6000);
    bus_write(16'hD000, 8'h00);
    for (int w = 0; w < 4; w++) probe_cpu('h8000 + w * 'h2000 + 9);
    for (int s = 0; s < 4; s++) begin
      bus_write(16'hD000, 8'(s << 3));
      for (int k = 0; k < 8; k++) probe_vid(k * 1024 + 17, "R10 size");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule